// File: doc/BRIEF.md
# Reset-Time Configuration Strap Latch

This block gives a transceiver its power-on configuration without any management access. While the active-low chip reset is held, ten pins that normally carry receive data, receive status and LED outputs are treated as inputs. Each has a weak internal pull that sets its level when the board leaves it undriven. When reset is released, the levels are frozen into configuration outputs: a three-bit station address, the power-up values of the duplex, speed and auto-negotiation-enable control bits, an isolate flag and a three-bit interface configuration code.

Reset is asserted asynchronously and released through a two-stage synchroniser. The straps are captured on the clock edge at which the synchronised reset goes high. The pin output enables stay low through reset and rise one clock after that capture edge, so the pins return to their normal output role only after their levels have been latched. The register file that consumes these defaults, the pads themselves and the meaning of the configuration code belong to other blocks.

Top module: `strap_latch`

## Requirements
- R1: The strap input bus `strap_pad_i` has fixed bit positions. Bit 0 is receive data 3, bit 1 is receive data 2, bit 2 is receive data 1, bit 3 is receive data 0, bit 4 is LED1, bit 5 is LED0, bit 6 is receive error, bit 7 is collision, bit 8 is carrier sense and bit 9 is receive data valid.
- R2: While `rst_n` is low, every configuration output equals the pull default of its pin. Pins 0, 3, 4 and 5 pull up and all other pins pull down, so the address reads 3'b001, duplex, speed and auto-negotiation read 1, and isolate and the code read 0.
- R3: On the clock edge at which the synchronised reset rises, the strap outputs take the pin levels present at that edge. The address is formed as {bit 2, bit 1, bit 0}, duplex from bit 3, speed from bit 4, auto-negotiation enable from bit 5, isolate from bit 6, and the code as {bit 9, bit 8, bit 7}.
- R4: After capture, the strap outputs hold their values whatever the pins do, until `rst_n` is asserted again.
- R5: `pad_oe` is all zeros while `rst_n` is low. It drops asynchronously on assertion and stays low through the synchroniser stages and on the capture edge itself.
- R6: `pad_oe` rises on all ten pins together, exactly one clock edge after the capture edge.
- R7: The synchronised release takes two clock edges after `rst_n` goes high. Straps are captured on the second edge, and `pad_oe` rises on the third.
- R8: A pin left undriven during reset is latched as its pull default, pin by pin, while driven pins are latched at their driven levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assertion |
| strap_pad_i | input | 10 | Levels seen on the shared pins (bit order in R1) |
| phy_addr | output | 3 | Latched station address |
| dflt_duplex | output | 1 | Power-up value of control bit 8 (full duplex) |
| dflt_speed | output | 1 | Power-up value of control bit 13 (100 Mb/s) |
| dflt_aneg_en | output | 1 | Power-up value of control bit 12 (auto-negotiation enable) |
| iso_strap | output | 1 | Latched isolate request |
| cfg_code | output | 3 | Latched interface configuration code |
| pad_oe | output | 10 | Per-pin output enable, same bit order as `strap_pad_i` |

## Verification
Two things overlap at the capture boundary: the strap capture and the pins turning around to their output role. In a real board the pins start moving as soon as the configuration is taken. The bench changes every pin level immediately after the capture edge, while `pad_oe` is still low. It then checks that the captured values do not follow the new levels and that the enables rise exactly one edge later. A second overlap is reset re-assertion while the enables are already high. The bench drops `rst_n` between edges and expects the enables and the strap outputs to fall back to their defaults at once, without waiting for a clock edge.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_STRAPS = 10;

  // Pin positions on the strap bus; the address and code fields depend on them.
  localparam int PIN_ADDR0  = 0;
  localparam int PIN_ADDR1  = 1;
  localparam int PIN_ADDR2  = 2;
  localparam int PIN_DUPLEX = 3;
  localparam int PIN_SPEED  = 4;
  localparam int PIN_ANEG   = 5;
  localparam int PIN_ISO    = 6;
  localparam int PIN_CFG0   = 7;
  localparam int PIN_CFG1   = 8;
  localparam int PIN_CFG2   = 9;

  // Weak pull level of each pin: 1 = pull-up, 0 = pull-down.
  localparam logic [NUM_STRAPS-1:0] PULL_DEFAULT = 10'b00_0011_1001;

  typedef struct packed {
    logic [2:0] addr;
    logic       duplex;
    logic       speed;
    logic       aneg;
    logic       iso;
    logic [2:0] cfg;
  } strap_cfg_t;

  function automatic strap_cfg_t decode_straps(input logic [NUM_STRAPS-1:0] v);
    strap_cfg_t c;
    c.addr   = {v[PIN_ADDR2], v[PIN_ADDR1], v[PIN_ADDR0]};
    c.duplex = v[PIN_DUPLEX];
    c.speed  = v[PIN_SPEED];
    c.aneg   = v[PIN_ANEG];
    c.iso    = v[PIN_ISO];
    c.cfg    = {v[PIN_CFG2], v[PIN_CFG1], v[PIN_CFG0]};
    return c;
  endfunction
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n,
  output logic capture_en
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
  // High during the cycle whose closing edge releases the synchronised reset.
  assign capture_en = chain_q[STAGES-2] & ~chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int WIDTH = NUM_STRAPS,
  parameter logic [WIDTH-1:0] RESET_VAL = PULL_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] strap_q
);
  logic [WIDTH-1:0] strap_d;

  always_comb begin
    strap_d = strap_q;
    if (capture_en) strap_d = pad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= RESET_VAL;
    else        strap_q <= strap_d;
  end
endmodule

// File: rtl/strap_oe_ctrl.sv
module strap_oe_ctrl #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_sync_n,
  output logic [WIDTH-1:0] pad_oe
);
  logic release_q;
  logic release_d;

  always_comb begin
    release_d = rst_sync_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) release_q <= 1'b0;
    else        release_q <= release_d;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin_oe
    assign pad_oe[i] = release_q;
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] strap_pad_i,
  output logic [2:0]            phy_addr,
  output logic                  dflt_duplex,
  output logic                  dflt_speed,
  output logic                  dflt_aneg_en,
  output logic                  iso_strap,
  output logic [2:0]            cfg_code,
  output logic [NUM_STRAPS-1:0] pad_oe
);
  logic                  rst_sync_n;
  logic                  capture_en;
  logic [NUM_STRAPS-1:0] strap_q;
  strap_cfg_t            cfg;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .capture_en (capture_en)
  );

  strap_capture #(.WIDTH(NUM_STRAPS), .RESET_VAL(PULL_DEFAULT)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .pad_i      (strap_pad_i),
    .strap_q    (strap_q)
  );

  strap_oe_ctrl #(.WIDTH(NUM_STRAPS)) u_oe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .pad_oe     (pad_oe)
  );

  assign cfg          = decode_straps(strap_q);
  assign phy_addr     = cfg.addr;
  assign dflt_duplex  = cfg.duplex;
  assign dflt_speed   = cfg.speed;
  assign dflt_aneg_en = cfg.aneg;
  assign iso_strap    = cfg.iso;
  assign cfg_code     = cfg.cfg;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic [9:0] strap_pad_i,
  input logic [2:0] phy_addr,
  input logic       dflt_duplex,
  input logic       dflt_speed,
  input logic       dflt_aneg_en,
  input logic       iso_strap,
  input logic [2:0] cfg_code,
  input logic [9:0] pad_oe
);
  logic [9:0] seen;
  assign seen = {cfg_code, iso_strap, dflt_aneg_en, dflt_speed, dflt_duplex, phy_addr};

  AST_CAPTURE_MATCHES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !$past(rst_sync_n)) |-> (seen == $past(strap_pad_i))); // R3

  AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && $past(rst_sync_n)) |-> $stable(seen)); // R4

  AST_OE_LOW_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (pad_oe == 10'd0)); // R5

  AST_OE_ONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe[0]) |-> ($past(rst_sync_n, 1) && !$past(rst_sync_n, 2))); // R6

  AST_OE_ALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe == 10'd0) || (pad_oe == 10'h3FF))); // R6
endmodule

bind strap_latch strap_latch_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .strap_pad_i  (strap_pad_i),
  .phy_addr     (phy_addr),
  .dflt_duplex  (dflt_duplex),
  .dflt_speed   (dflt_speed),
  .dflt_aneg_en (dflt_aneg_en),
  .iso_strap    (iso_strap),
  .cfg_code     (cfg_code),
  .pad_oe       (pad_oe)
);

// File: tb/strap_latch_bench.sv
module strap_latch_bench;
  logic       clk;
  logic       rst_n;
  logic [9:0] drv_en;
  logic [9:0] drv_val;
  logic [9:0] pad;
  logic [2:0] phy_addr;
  logic       dflt_duplex, dflt_speed, dflt_aneg_en, iso_strap;
  logic [2:0] cfg_code;
  logic [9:0] pad_oe;
  int         n_checks;
  int         n_errors;
  bit         done;

  localparam logic [9:0] PULLS = 10'b00_0011_1001; // R2 pull-ups on pins 0,3,4,5

  // Weak-driver resolution: an undriven pin settles to its pull level (R8).
  function automatic logic [9:0] resolve(input logic [9:0] en, input logic [9:0] val);
    return (en & val) | (~en & PULLS);
  endfunction

  // Expected output vector {cfg, iso, aneg, speed, duplex, addr} from pin levels (R1, R3).
  function automatic logic [9:0] expect_out(input logic [9:0] p);
    return {p[9], p[8], p[7], p[6], p[5], p[4], p[3], p[2], p[1], p[0]};
  endfunction

  assign pad = resolve(drv_en, drv_val);

  strap_latch u_strap_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_pad_i  (pad),
    .phy_addr     (phy_addr),
    .dflt_duplex  (dflt_duplex),
    .dflt_speed   (dflt_speed),
    .dflt_aneg_en (dflt_aneg_en),
    .iso_strap    (iso_strap),
    .cfg_code     (cfg_code),
    .pad_oe       (pad_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] outs();
    return {cfg_code, iso_strap, dflt_aneg_en, dflt_speed, dflt_duplex, phy_addr};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Full reset cycle with given pin drive during reset; checks the release timeline.
  task automatic run_cycle(input logic [9:0] en, input logic [9:0] val);
    logic [9:0] exp;
    @(negedge clk);
    rst_n   = 1'b0;
    drv_en  = en;
    drv_val = val;
    #2;
    check("R2 defaults in reset", outs(), expect_out(PULLS));
    check("R5 oe low in reset", pad_oe, 10'd0);
    @(negedge clk);
    exp = expect_out(resolve(en, val));
    rst_n = 1'b1;
    @(posedge clk); // first sync stage
    @(negedge clk);
    check("R7 no capture on first edge", outs(), expect_out(PULLS));
    check("R5 oe low after first edge", pad_oe, 10'd0);
    @(posedge clk); // capture edge
    @(negedge clk);
    check("R3 R8 captured values", outs(), exp);
    check("R5 oe low on capture edge", pad_oe, 10'd0);
    // Turnaround: pins change right after capture.
    drv_en  = 10'h3FF;
    drv_val = ~resolve(en, val);
    @(posedge clk);
    @(negedge clk);
    check("R6 oe released one edge after capture", pad_oe, 10'h3FF);
    check("R4 held through turnaround", outs(), exp);
    for (int k = 0; k < 3; k++) begin
      drv_en  = 10'($urandom);
      drv_val = 10'($urandom);
      @(negedge clk);
    end
    check("R4 held under pin activity", outs(), exp);
    check("R6 oe stays high", pad_oe, 10'h3FF);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 0;
    rst_n = 1'b0; drv_en = '0; drv_val = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // Directed: all floating gives address 001 and pull defaults (R8, R2).
    run_cycle(10'h000, 10'h000);
    check("R8 floating address", {7'd0, phy_addr}, 10'd1);
    // Directed: all driven high and all driven low (R1 bit order).
    run_cycle(10'h3FF, 10'h3FF);
    run_cycle(10'h3FF, 10'h000);
    // Directed: single pins driven against their pulls, one at a time (R1).
    for (int b = 0; b < 10; b++) run_cycle(10'(1 << b), ~PULLS);
    // Async re-assertion between edges while enabled (R5, R2).
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R5 oe drops asynchronously", pad_oe, 10'd0);
    check("R2 defaults restored asynchronously", outs(), expect_out(PULLS));
    // Random patterns with random floating masks.
    for (int i = 0; i < 40; i++) run_cycle(10'($urandom), 10'($urandom));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule